// File: doc/BRIEF.md
# Home-Node Directory Coherence Controller

This block is the home agent for a range of memory blocks in a multiprocessor that keeps caches coherent without broadcast. For every block it owns, it keeps a three-way coherence state (Uncached, Shared or Exclusive), a presence vector with one bit per processor, and the block's data in a small local store. Caches send it read misses, write misses and write-backs. For each one the controller first rewrites the directory entry and then sends the point-to-point messages needed to complete the request: invalidations to other holders, a fetch or fetch-and-invalidate to a dirty owner, and finally a data reply to the requester.

Requests are handled one at a time. Each request is accepted on a valid/ready input and treated as atomic. Outgoing messages leave one per cycle on a valid/ready output that carries a message kind, a destination processor, the block address and a data word. While a fetch is outstanding, the owner's copy of the block comes back on a separate data-return input. A new request is accepted only after the last message of the current one has been taken.

Top module: `dirc_home`

## Requirements
- R1: After reset every block is Uncached with an empty presence vector and zero data; `req_ready` is 1 and `msg_valid` is 0.
- R2: The request kind encodings are 0 read miss, 1 write miss and 2 write-back; kind 3 is ignored. The message kind encodings are 0 invalidate, 1 fetch, 2 fetch-and-invalidate and 3 data reply. Every message carries the address of the request being served.
- R3: A read miss to an Uncached or Shared block produces exactly one data reply to the requester, carrying the stored data. The block becomes Shared and the requester is added to the presence vector.
- R4: A write miss to a Shared block first sends an invalidate to every holder other than the requester, in ascending processor index, and then sends a data reply. The requester then becomes sole Exclusive owner. If the requester is the only holder, no invalidate is sent.
- R5: A read miss to an Exclusive block sends a fetch to the owner and waits for the returned data. That data is written to the store and forwarded in the data reply. The block becomes Shared, held by both the old owner and the requester.
- R6: A write miss to a block that another processor holds Exclusive sends a fetch-and-invalidate to that owner, replies with the returned data, and makes the requester sole Exclusive owner. A write miss from the current owner gets only a data reply.
- R7: A write-back from the Exclusive owner writes its data to the store, leaves the block Uncached with an empty presence vector, and sends no message. A write-back from any other processor changes nothing.
- R8: The first message of a request is valid in the cycle after acceptance. Each later invalidate and the data reply follow one cycle after the previous message is taken, when the output is ready. A data reply after a fetch appears one cycle after the returned data is accepted.
- R9: While a request is in progress `req_ready` is 0. A message held back by `msg_ready` low keeps all its fields unchanged.
- R10: Data-return input pulses that arrive when no fetch is outstanding have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_kind | input | 2 | Request kind (R2) |
| req_src | input | $clog2(NUM_PROCS) | Requesting processor |
| req_addr | input | $clog2(NUM_BLOCKS) | Block address |
| req_data | input | DATA_W | Write-back data |
| fb_valid | input | 1 | Owner's returned data valid |
| fb_data | input | DATA_W | Owner's returned data |
| msg_valid | output | 1 | Outgoing message present |
| msg_ready | input | 1 | Outgoing message taken |
| msg_kind | output | 2 | Message kind (R2) |
| msg_dest | output | $clog2(NUM_PROCS) | Destination processor |
| msg_addr | output | $clog2(NUM_BLOCKS) | Block address |
| msg_data | output | DATA_W | Data for a data reply, zero otherwise |

## Verification
A request is accepted on the rising edge where `req_valid` and `req_ready` are both high, and its first message is due in the very next cycle. Each further invalidate or reply is due one cycle after the previous one is taken. After a fetch, the reply is due two cycles after the fetch is taken, because the returned data is driven for one cycle in between. The bench keeps `msg_ready` high, samples on falling edges, and records the cycle number of each message relative to acceptance. It compares these cycle numbers with those values as well as the kinds, destinations and data. Directory state is never read directly: it is inferred from the messages a later request produces, and a write-back shows its effect only through the message pattern of the next miss to that block.

// File: rtl/dirc_pkg.sv
package dirc_pkg;

    typedef enum logic [1:0] {
        RQ_READ_MISS  = 2'd0,
        RQ_WRITE_MISS = 2'd1,
        RQ_WRITE_BACK = 2'd2
    } req_kind_e;

    typedef enum logic [1:0] {
        MS_INVAL      = 2'd0,
        MS_FETCH      = 2'd1,
        MS_FETCH_INV  = 2'd2,
        MS_DATA_REPLY = 2'd3
    } msg_kind_e;

    typedef enum logic [1:0] {
        DS_UNCACHED = 2'd0,
        DS_SHARED   = 2'd1,
        DS_EXCL     = 2'd2
    } dir_state_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_INVAL,
        ST_FETCH_SEND,
        ST_FETCH_WAIT,
        ST_REPLY
    } eng_state_e;

    // Index width for a count of items (at least one bit).
    function automatic int idx_bits(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/dirc_pick_lowest.sv
module dirc_pick_lowest
    import dirc_pkg::*;
#(
    parameter int N = 4,
    localparam int IW = idx_bits(N)
) (
    input  logic [N-1:0]  vec,
    output logic [N-1:0]  first,
    output logic [IW-1:0] idx,
    output logic          any
);

    // One-hot of the lowest set bit.
    generate
        for (genvar i = 0; i < N; i++) begin : g_bit
            if (i == 0) begin : g_lo
                assign first[i] = vec[i];
            end else begin : g_hi
                assign first[i] = vec[i] & ~(|vec[i-1:0]);
            end
        end
    endgenerate

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (first[i]) idx = idx | IW'(i);
        end
    end

    assign any = |vec;

endmodule

// File: rtl/dirc_dir_store.sv
module dirc_dir_store
    import dirc_pkg::*;
#(
    parameter int NUM_PROCS  = 4,
    parameter int NUM_BLOCKS = 8,
    parameter int DATA_W     = 16,
    localparam int AW = idx_bits(NUM_BLOCKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [AW-1:0]        rd_addr,
    output dir_state_e           rd_state,
    output logic [NUM_PROCS-1:0] rd_sharers,
    output logic [DATA_W-1:0]    rd_data,
    input  logic                 dir_we,
    input  logic [AW-1:0]        dir_waddr,
    input  dir_state_e           dir_wstate,
    input  logic [NUM_PROCS-1:0] dir_wsharers,
    input  logic                 mem_we,
    input  logic [AW-1:0]        mem_waddr,
    input  logic [DATA_W-1:0]    mem_wdata
);

    dir_state_e           state_q [NUM_BLOCKS];
    logic [NUM_PROCS-1:0] share_q [NUM_BLOCKS];
    logic [DATA_W-1:0]    data_q  [NUM_BLOCKS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int b = 0; b < NUM_BLOCKS; b++) begin
                state_q[b] <= DS_UNCACHED;
                share_q[b] <= '0;
                data_q[b]  <= '0;
            end
        end else begin
            if (dir_we) begin
                state_q[dir_waddr] <= dir_wstate;
                share_q[dir_waddr] <= dir_wsharers;
            end
            if (mem_we) begin
                data_q[mem_waddr] <= mem_wdata;
            end
        end
    end

    assign rd_state   = state_q[rd_addr];
    assign rd_sharers = share_q[rd_addr];
    assign rd_data    = data_q[rd_addr];

endmodule

// File: rtl/dirc_engine.sv
module dirc_engine
    import dirc_pkg::*;
#(
    parameter int NUM_PROCS  = 4,
    parameter int NUM_BLOCKS = 8,
    parameter int DATA_W     = 16,
    localparam int PW = idx_bits(NUM_PROCS),
    localparam int AW = idx_bits(NUM_BLOCKS)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_kind,
    input  logic [PW-1:0]        req_src,
    input  logic [AW-1:0]        req_addr,
    input  logic [DATA_W-1:0]    req_data,
    input  logic                 fb_valid,
    input  logic [DATA_W-1:0]    fb_data,
    output logic                 msg_valid,
    input  logic                 msg_ready,
    output logic [1:0]           msg_kind,
    output logic [PW-1:0]        msg_dest,
    output logic [AW-1:0]        msg_addr,
    output logic [DATA_W-1:0]    msg_data,
    output logic [AW-1:0]        rd_addr,
    input  dir_state_e           rd_state,
    input  logic [NUM_PROCS-1:0] rd_sharers,
    input  logic [DATA_W-1:0]    rd_data,
    output logic                 dir_we,
    output logic [AW-1:0]        dir_waddr,
    output dir_state_e           dir_wstate,
    output logic [NUM_PROCS-1:0] dir_wsharers,
    output logic                 mem_we,
    output logic [AW-1:0]        mem_waddr,
    output logic [DATA_W-1:0]    mem_wdata
);

    eng_state_e           st_q, st_d;
    logic [PW-1:0]        src_q;
    logic [AW-1:0]        addr_q;
    logic [NUM_PROCS-1:0] pend_q, pend_d;
    logic [DATA_W-1:0]    rdata_q, rdata_d;
    msg_kind_e            fkind_q, fkind_d;
    logic [PW-1:0]        fdest_q, fdest_d;

    logic [NUM_PROCS-1:0] src_oh, owner_oh, pend_first, others;
    logic [PW-1:0]        owner_idx, pend_idx;
    logic                 owner_any, pend_any;
    logic                 accept, excl_held, is_owner;

    dirc_pick_lowest #(.N(NUM_PROCS)) u_owner (
        .vec  (rd_sharers),
        .first(owner_oh),
        .idx  (owner_idx),
        .any  (owner_any)
    );

    dirc_pick_lowest #(.N(NUM_PROCS)) u_pend (
        .vec  (pend_q),
        .first(pend_first),
        .idx  (pend_idx),
        .any  (pend_any)
    );

    assign src_oh    = NUM_PROCS'(1) << req_src;
    assign others    = rd_sharers & ~src_oh;
    assign req_ready = (st_q == ST_IDLE);
    assign accept    = req_valid && req_ready;
    assign rd_addr   = req_addr;
    assign excl_held = (rd_state == DS_EXCL) && owner_any;
    assign is_owner  = excl_held && (owner_oh == src_oh);

    // Next state: directory rewrite at acceptance, then message sequencing.
    always_comb begin
        st_d         = st_q;
        pend_d       = pend_q;
        rdata_d      = rdata_q;
        fkind_d      = fkind_q;
        fdest_d      = fdest_q;
        dir_we       = 1'b0;
        dir_waddr    = req_addr;
        dir_wstate   = rd_state;
        dir_wsharers = rd_sharers;
        mem_we       = 1'b0;
        mem_waddr    = req_addr;
        mem_wdata    = req_data;
        unique case (st_q)
            ST_IDLE: begin
                if (accept) begin
                    case (req_kind_e'(req_kind))
                        RQ_READ_MISS: begin
                            dir_we       = 1'b1;
                            dir_wstate   = DS_SHARED;
                            dir_wsharers = rd_sharers | src_oh;
                            rdata_d      = rd_data;
                            if (excl_held) begin
                                fkind_d = MS_FETCH;
                                fdest_d = owner_idx;
                                st_d    = ST_FETCH_SEND;
                            end else begin
                                st_d = ST_REPLY;
                            end
                        end
                        RQ_WRITE_MISS: begin
                            dir_we       = 1'b1;
                            dir_wstate   = DS_EXCL;
                            dir_wsharers = src_oh;
                            rdata_d      = rd_data;
                            if (excl_held && !is_owner) begin
                                fkind_d = MS_FETCH_INV;
                                fdest_d = owner_idx;
                                st_d    = ST_FETCH_SEND;
                            end else if (rd_state == DS_SHARED && others != '0) begin
                                pend_d = others;
                                st_d   = ST_INVAL;
                            end else begin
                                st_d = ST_REPLY;
                            end
                        end
                        RQ_WRITE_BACK: begin
                            if (is_owner) begin
                                dir_we       = 1'b1;
                                dir_wstate   = DS_UNCACHED;
                                dir_wsharers = '0;
                                mem_we       = 1'b1;
                            end
                        end
                        default: ;
                    endcase
                end
            end
            ST_INVAL: begin
                if (msg_ready) begin
                    pend_d = pend_q & ~pend_first;
                    if (pend_d == '0) st_d = ST_REPLY;
                end
            end
            ST_FETCH_SEND: begin
                if (msg_ready) st_d = ST_FETCH_WAIT;
            end
            ST_FETCH_WAIT: begin
                if (fb_valid) begin
                    mem_we    = 1'b1;
                    mem_waddr = addr_q;
                    mem_wdata = fb_data;
                    rdata_d   = fb_data;
                    st_d      = ST_REPLY;
                end
            end
            ST_REPLY: begin
                if (msg_ready) st_d = ST_IDLE;
            end
            default: st_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q    <= ST_IDLE;
            src_q   <= '0;
            addr_q  <= '0;
            pend_q  <= '0;
            rdata_q <= '0;
            fkind_q <= MS_FETCH;
            fdest_q <= '0;
        end else begin
            st_q    <= st_d;
            pend_q  <= pend_d;
            rdata_q <= rdata_d;
            fkind_q <= fkind_d;
            fdest_q <= fdest_d;
            if (accept) begin
                src_q  <= req_src;
                addr_q <= req_addr;
            end
        end
    end

    // Outgoing message fields.
    always_comb begin
        msg_valid = 1'b0;
        msg_kind  = MS_DATA_REPLY;
        msg_dest  = src_q;
        msg_addr  = addr_q;
        msg_data  = '0;
        case (st_q)
            ST_INVAL: begin
                msg_valid = pend_any;
                msg_kind  = MS_INVAL;
                msg_dest  = pend_idx;
            end
            ST_FETCH_SEND: begin
                msg_valid = 1'b1;
                msg_kind  = fkind_q;
                msg_dest  = fdest_q;
            end
            ST_REPLY: begin
                msg_valid = 1'b1;
                msg_data  = rdata_q;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/dirc_home.sv
module dirc_home
    import dirc_pkg::*;
#(
    parameter int NUM_PROCS  = 4,
    parameter int NUM_BLOCKS = 8,
    parameter int DATA_W     = 16,
    localparam int PW = idx_bits(NUM_PROCS),
    localparam int AW = idx_bits(NUM_BLOCKS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [1:0]        req_kind,
    input  logic [PW-1:0]     req_src,
    input  logic [AW-1:0]     req_addr,
    input  logic [DATA_W-1:0] req_data,
    input  logic              fb_valid,
    input  logic [DATA_W-1:0] fb_data,
    output logic              msg_valid,
    input  logic              msg_ready,
    output logic [1:0]        msg_kind,
    output logic [PW-1:0]     msg_dest,
    output logic [AW-1:0]     msg_addr,
    output logic [DATA_W-1:0] msg_data
);

    logic [AW-1:0]        rd_addr, dir_waddr, mem_waddr;
    dir_state_e           rd_state, dir_wstate;
    logic [NUM_PROCS-1:0] rd_sharers, dir_wsharers;
    logic [DATA_W-1:0]    rd_data, mem_wdata;
    logic                 dir_we, mem_we;

    dirc_dir_store #(
        .NUM_PROCS (NUM_PROCS),
        .NUM_BLOCKS(NUM_BLOCKS),
        .DATA_W    (DATA_W)
    ) u_store (
        .clk         (clk),
        .rst         (rst),
        .rd_addr     (rd_addr),
        .rd_state    (rd_state),
        .rd_sharers  (rd_sharers),
        .rd_data     (rd_data),
        .dir_we      (dir_we),
        .dir_waddr   (dir_waddr),
        .dir_wstate  (dir_wstate),
        .dir_wsharers(dir_wsharers),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .mem_wdata   (mem_wdata)
    );

    dirc_engine #(
        .NUM_PROCS (NUM_PROCS),
        .NUM_BLOCKS(NUM_BLOCKS),
        .DATA_W    (DATA_W)
    ) u_engine (
        .clk         (clk),
        .rst         (rst),
        .req_valid   (req_valid),
        .req_ready   (req_ready),
        .req_kind    (req_kind),
        .req_src     (req_src),
        .req_addr    (req_addr),
        .req_data    (req_data),
        .fb_valid    (fb_valid),
        .fb_data     (fb_data),
        .msg_valid   (msg_valid),
        .msg_ready   (msg_ready),
        .msg_kind    (msg_kind),
        .msg_dest    (msg_dest),
        .msg_addr    (msg_addr),
        .msg_data    (msg_data),
        .rd_addr     (rd_addr),
        .rd_state    (rd_state),
        .rd_sharers  (rd_sharers),
        .rd_data     (rd_data),
        .dir_we      (dir_we),
        .dir_waddr   (dir_waddr),
        .dir_wstate  (dir_wstate),
        .dir_wsharers(dir_wsharers),
        .mem_we      (mem_we),
        .mem_waddr   (mem_waddr),
        .mem_wdata   (mem_wdata)
    );

endmodule

// File: rtl/dirc_home_chk.sv
module dirc_home_chk
    import dirc_pkg::*;
#(
    parameter int NUM_PROCS  = 4,
    parameter int NUM_BLOCKS = 8,
    parameter int DATA_W     = 16,
    localparam int PW = idx_bits(NUM_PROCS),
    localparam int AW = idx_bits(NUM_BLOCKS)
) (
    input logic              clk,
    input logic              rst,
    input logic              req_valid,
    input logic              req_ready,
    input logic [1:0]        req_kind,
    input logic [PW-1:0]     req_src,
    input logic [AW-1:0]     req_addr,
    input logic              msg_valid,
    input logic              msg_ready,
    input logic [1:0]        msg_kind,
    input logic [PW-1:0]     msg_dest,
    input logic [AW-1:0]     msg_addr,
    input logic [DATA_W-1:0] msg_data
);

    logic [PW-1:0] last_src;
    logic [AW-1:0] last_addr;

    always_ff @(posedge clk) begin
        if (rst) begin
            last_src  <= '0;
            last_addr <= '0;
        end else if (req_valid && req_ready) begin
            last_src  <= req_src;
            last_addr <= req_addr;
        end
    end

    // R8: a miss produces a message in the next cycle
    p_first_msg_r8: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && (req_kind == RQ_READ_MISS || req_kind == RQ_WRITE_MISS))
        |=> msg_valid);

    // R7: a write-back sends nothing and leaves the controller idle
    p_wb_silent_r7: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready && req_kind == RQ_WRITE_BACK) |=> (!msg_valid && req_ready));

    // R9: a stalled message keeps every field
    p_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && !msg_ready) |=> (msg_valid && $stable(msg_kind) && $stable(msg_dest)
                                       && $stable(msg_addr) && $stable(msg_data)));

    // R9: no new request while messages are pending
    p_busy_r9: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> !req_ready);

    // R3: data replies go to the requester
    p_reply_dest_r3: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == MS_DATA_REPLY) |-> (msg_dest == last_src));

    // R4: invalidates never target the requester
    p_inval_other_r4: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_kind == MS_INVAL) |-> (msg_dest != last_src));

    // R2: every message names the block of the request in service
    p_addr_r2: assert property (@(posedge clk) disable iff (rst)
        msg_valid |-> (msg_addr == last_addr));

    // R8: the reply closes the request
    p_reply_ends_r8: assert property (@(posedge clk) disable iff (rst)
        (msg_valid && msg_ready && msg_kind == MS_DATA_REPLY) |=> req_ready);

endmodule

bind dirc_home dirc_home_chk #(
    .NUM_PROCS (NUM_PROCS),
    .NUM_BLOCKS(NUM_BLOCKS),
    .DATA_W    (DATA_W)
) u_chk (
    .clk      (clk),
    .rst      (rst),
    .req_valid(req_valid),
    .req_ready(req_ready),
    .req_kind (req_kind),
    .req_src  (req_src),
    .req_addr (req_addr),
    .msg_valid(msg_valid),
    .msg_ready(msg_ready),
    .msg_kind (msg_kind),
    .msg_dest (msg_dest),
    .msg_addr (msg_addr),
    .msg_data (msg_data)
);

// File: tb/dirc_home_bench.sv
`timescale 1ns/1ps
module dirc_home_bench;

    localparam int RD = 0, WR = 1, WB = 2;
    localparam int K_INV = 0, K_FET = 1, K_FINV = 2, K_REP = 3;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_kind = '0;
    logic [1:0]  req_src = '0;
    logic [2:0]  req_addr = '0;
    logic [15:0] req_data = '0;
    logic        fb_valid = 1'b0;
    logic [15:0] fb_data = '0;
    logic        msg_valid;
    logic        msg_ready = 1'b1;
    logic [1:0]  msg_kind;
    logic [1:0]  msg_dest;
    logic [2:0]  msg_addr;
    logic [15:0] msg_data;

    int n_chk = 0;
    int n_fail = 0;
    int n_msg;
    int rk[16], rdst[16], radr[16], rdat[16], rcy[16];

    always #2.5 clk = ~clk;

    dirc_home u_dirc_home (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_src(req_src), .req_addr(req_addr), .req_data(req_data),
        .fb_valid(fb_valid), .fb_data(fb_data),
        .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_kind(msg_kind),
        .msg_dest(msg_dest), .msg_addr(msg_addr), .msg_data(msg_data)
    );

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Issue one request and collect its messages; a fetch is answered with fbv.
    task automatic run_req(input int kind, input int src, input int addr, input int data, input int fbv);
        bit done = 0;
        bit fb_pend = 0;
        @(negedge clk);
        check_eq("R9", "ready before request", int'(req_ready), 1);
        req_valid = 1'b1;
        req_kind  = 2'(kind);
        req_src   = 2'(src);
        req_addr  = 3'(addr);
        req_data  = 16'(data);
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        n_msg = 0;
        for (int c = 1; c <= 12 && !done; c++) begin
            fb_valid = fb_pend;
            fb_data  = 16'(fbv);
            fb_pend  = 0;
            if (msg_valid && n_msg < 16) begin
                rk[n_msg]   = int'(msg_kind);
                rdst[n_msg] = int'(msg_dest);
                radr[n_msg] = int'(msg_addr);
                rdat[n_msg] = int'(msg_data);
                rcy[n_msg]  = c;
                if (msg_kind == 2'(K_REP)) done = 1;
                if (msg_kind == 2'(K_FET) || msg_kind == 2'(K_FINV)) fb_pend = 1;
                n_msg++;
            end
            @(posedge clk);
            @(negedge clk);
        end
        fb_valid = 1'b0;
    endtask

    task automatic expect_msg(input string req, input int i, input int kind, input int dest,
                              input int addr, input int data, input int cyc);
        check_eq(req, $sformatf("msg%0d kind", i), rk[i], kind);
        check_eq(req, $sformatf("msg%0d dest", i), rdst[i], dest);
        check_eq(req, $sformatf("msg%0d addr", i), radr[i], addr);
        if (kind == K_REP) check_eq(req, $sformatf("msg%0d data", i), rdat[i], data);
        if (cyc > 0) check_eq(req, $sformatf("msg%0d cycle", i), rcy[i], cyc);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check_eq("R1", "req_ready after reset", int'(req_ready), 1);
        check_eq("R1", "msg_valid after reset", int'(msg_valid), 0);
        run_req(RD, 0, 0, 0, 0);
        check_eq("R1", "message count", n_msg, 1);
        expect_msg("R1", 0, K_REP, 0, 0, 0, 1);
    endtask

    task automatic t_read_uncached();
        run_req(RD, 1, 3, 0, 0);
        check_eq("R3", "message count", n_msg, 1);
        expect_msg("R3", 0, K_REP, 1, 3, 0, 1);
    endtask

    task automatic t_write_back();
        run_req(WR, 0, 2, 0, 0);
        check_eq("R7", "write miss count", n_msg, 1);
        run_req(WB, 0, 2, 16'h1234, 0);
        check_eq("R7", "write-back messages", n_msg, 0);
        run_req(RD, 1, 2, 0, 0);
        check_eq("R7", "read after write-back count", n_msg, 1);
        expect_msg("R7", 0, K_REP, 1, 2, 16'h1234, 1);
        run_req(3, 2, 2, 0, 0);
        check_eq("R2", "unused kind messages", n_msg, 0);
    endtask

    task automatic t_invalidate();
        run_req(RD, 0, 5, 0, 0);
        run_req(RD, 2, 5, 0, 0);
        run_req(RD, 3, 5, 0, 0);
        run_req(WR, 2, 5, 0, 0);
        check_eq("R4", "write miss on shared count", n_msg, 3);
        expect_msg("R4", 0, K_INV, 0, 5, 0, 1);
        expect_msg("R4", 1, K_INV, 3, 5, 0, 2);
        expect_msg("R8", 2, K_REP, 2, 5, 0, 3);
        run_req(RD, 1, 5, 0, 16'hBEEF);
        check_eq("R5", "read on exclusive count", n_msg, 2);
        expect_msg("R5", 0, K_FET, 2, 5, 0, 1);
        expect_msg("R5", 1, K_REP, 1, 5, 16'hBEEF, 3);
        run_req(WR, 3, 5, 0, 0);
        check_eq("R5", "sharers after fetch count", n_msg, 3);
        expect_msg("R5", 0, K_INV, 1, 5, 0, 1);
        expect_msg("R5", 1, K_INV, 2, 5, 0, 2);
        expect_msg("R5", 2, K_REP, 3, 5, 16'hBEEF, 3);
    endtask

    task automatic t_steal();
        run_req(WR, 0, 6, 0, 0);
        run_req(WR, 1, 6, 0, 16'h0A0A);
        check_eq("R6", "steal count", n_msg, 2);
        expect_msg("R6", 0, K_FINV, 0, 6, 0, 1);
        expect_msg("R6", 1, K_REP, 1, 6, 16'h0A0A, 3);
        run_req(RD, 2, 6, 0, 16'h0B0B);
        check_eq("R6", "new owner fetch count", n_msg, 2);
        expect_msg("R6", 0, K_FET, 1, 6, 0, 1);
        expect_msg("R6", 1, K_REP, 2, 6, 16'h0B0B, 3);
    endtask

    task automatic t_only_holder();
        run_req(RD, 3, 7, 0, 0);
        run_req(WR, 3, 7, 0, 0);
        check_eq("R4", "sole sharer upgrade count", n_msg, 1);
        expect_msg("R4", 0, K_REP, 3, 7, 0, 1);
        run_req(WR, 3, 7, 0, 0);
        check_eq("R6", "owner rewrite count", n_msg, 1);
        expect_msg("R6", 0, K_REP, 3, 7, 0, 1);
    endtask

    task automatic t_wb_stranger();
        run_req(WR, 0, 4, 0, 0);
        run_req(WB, 1, 4, 16'h5555, 0);
        check_eq("R7", "stranger write-back messages", n_msg, 0);
        run_req(RD, 2, 4, 0, 16'h7777);
        check_eq("R7", "owner kept count", n_msg, 2);
        expect_msg("R7", 0, K_FET, 0, 4, 0, 1);
        expect_msg("R7", 1, K_REP, 2, 4, 16'h7777, 3);
    endtask

    task automatic t_stray_data();
        @(negedge clk);
        fb_valid = 1'b1;
        fb_data  = 16'h9999;
        repeat (2) @(negedge clk);
        fb_valid = 1'b0;
        run_req(RD, 0, 3, 0, 0);
        check_eq("R10", "count after stray data", n_msg, 1);
        expect_msg("R10", 0, K_REP, 0, 3, 0, 1);
    endtask

    task automatic t_stall();
        @(negedge clk);
        msg_ready = 1'b0;
        req_valid = 1'b1;
        req_kind  = 2'(RD);
        req_src   = 2'd2;
        req_addr  = 3'd1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        for (int i = 0; i < 3; i++) begin
            check_eq("R9", "held valid", int'(msg_valid), 1);
            check_eq("R9", "held dest", int'(msg_dest), 2);
            check_eq("R9", "held kind", int'(msg_kind), K_REP);
            check_eq("R9", "busy ready", int'(req_ready), 0);
            @(negedge clk);
        end
        msg_ready = 1'b1;
        @(negedge clk);
        check_eq("R9", "released valid", int'(msg_valid), 0);
        check_eq("R9", "released ready", int'(req_ready), 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_read_uncached();
        t_write_back();
        t_invalidate();
        t_steal();
        t_only_holder();
        t_wb_stranger();
        t_stray_data();
        t_stall();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule